// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus with word addresses and separate read and write strobes. A programmable divider turns the input clock into a slow tick, for example one tick per millisecond. An up-counter advances once per tick. When the count meets a programmed limit while the watchdog is running, the count wraps to zero. If reset generation is enabled, the block also asserts a system reset request for a fixed number of cycles.

Software sets the divide value, the three enable bits and the reset-enable bit in a control word. It sets the expiry limit in the lower half of a second word and reads the live count from the upper half of that same word. Writing anything to a third word restarts the count. The remaining time is the limit field minus the count field. Software keeps the system alive by writing that restart word before the count reaches the limit.

Top module: `tickdog_top`

## Requirements
- R1: After reset, every register reads zero and `rst_req` is low.
- R2: The control word sits at word address 0 (byte 0x0). Bits 25 (divider enable), 24 (counter clock enable), 21 (reset enable), 18 (watchdog enable) and 17:0 (divide value) are stored and read back. All other bits read zero.
- R3: The limit word sits at word address 2 (byte 0x8). Bits 15:0 hold the writable limit. Bits 31:16 read the current count, and writes to bits 31:16 are ignored.
- R4: A write of any data to word address 3 (byte 0xC) restarts the count at zero and restarts the prescaler, taking effect at that clock edge. Reads of word 3 return zero. Word 1 reads zero and ignores writes. With the read strobe low, read data is zero.
- R5: The count and prescaler advance only while bits 25, 24 and 18 are all set. Otherwise they hold their values.
- R6: With divide value D, the count rises by one every max(D,1) clock cycles, measured from a restart.
- R7: Expiry occurs on an edge where the block is running and the count equals the limit. At that edge the count becomes zero and the prescaler restarts.
- R8: If bit 21 is set, an expiry drives `rst_req` high for exactly 4 cycles, starting right after the expiry edge. If bit 21 is clear, an expiry leaves `rst_req` low.
- R9: Clearing bit 18 stops the watchdog. The other control fields and the count value are kept.
- R10: A restart write on the same edge as an expiry takes priority, so no reset pulse is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and strobe |
| rst_req | output | 1 | System reset request |

## Verification
Read data is combinational, so a read shows the register contents in the same cycle the address is presented. Register writes, restarts, count steps and expiry all take effect at the rising edge that samples them. `rst_req` rises right after the expiry edge and stays high for four cycles. The bench's reference model steps once per rising edge using the inputs held across that edge. It compares `rst_req` and the read data 1 ns after the edge, when the design has settled and the inputs have not yet changed. Directed checks count edges from the restart write, so their expected counts and pulse lengths follow directly from the divide value and the limit.

// File: rtl/tickdog_pkg.sv
`timescale 1ns/1ps
package tickdog_pkg;
   localparam int unsigned BUS_W      = 32;
   // word addresses (byte offset / 4)
   localparam int unsigned WA_CTRL    = 0;
   localparam int unsigned WA_LIMIT   = 2;
   localparam int unsigned WA_KICK    = 3;
   // control bit positions
   localparam int unsigned BIT_DIVEN  = 25;
   localparam int unsigned BIT_CLKEN  = 24;
   localparam int unsigned BIT_RSTEN  = 21;
   localparam int unsigned BIT_WDEN   = 18;
   localparam int unsigned MAX_DIV_W  = 18;
   // limit/count word layout
   localparam int unsigned MAX_CNT_W  = 16;
   localparam int unsigned CNT_SHIFT  = 16;
endpackage

// File: rtl/tickdog_regs.sv
`timescale 1ns/1ps
module tickdog_regs
   import tickdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DIV_W  = 18,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  count,
   output logic              run,
   output logic              rst_en,
   output logic [DIV_W-1:0]  div,
   output logic [CNT_W-1:0]  limit,
   output logic              kick
);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(WA_CTRL);
   localparam logic [ADDR_W-1:0] A_LIMIT = ADDR_W'(WA_LIMIT);
   localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(WA_KICK);

   logic             div_en_q, clk_en_q, rst_en_q, wd_en_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] limit_q;
   logic             sel_ctrl, sel_limit, sel_kick;
   logic [BUS_W-1:0] ctrl_word, limit_word;

   assign sel_ctrl  = (bus_addr == A_CTRL);
   assign sel_limit = (bus_addr == A_LIMIT);
   assign sel_kick  = (bus_addr == A_KICK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_en_q <= 1'b0;
         clk_en_q <= 1'b0;
         rst_en_q <= 1'b0;
         wd_en_q  <= 1'b0;
         div_q    <= '0;
         limit_q  <= '0;
      end else if (bus_wr) begin
         if (sel_ctrl) begin
            div_en_q <= bus_wdata[BIT_DIVEN];
            clk_en_q <= bus_wdata[BIT_CLKEN];
            rst_en_q <= bus_wdata[BIT_RSTEN];
            wd_en_q  <= bus_wdata[BIT_WDEN];
            div_q    <= bus_wdata[DIV_W-1:0];
         end
         if (sel_limit) begin
            limit_q <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   assign kick   = bus_wr && sel_kick;
   assign run    = div_en_q && clk_en_q && wd_en_q;
   assign rst_en = rst_en_q;
   assign div    = div_q;
   assign limit  = limit_q;

   always_comb begin
      ctrl_word             = BUS_W'(div_q);
      ctrl_word[BIT_DIVEN]  = div_en_q;
      ctrl_word[BIT_CLKEN]  = clk_en_q;
      ctrl_word[BIT_RSTEN]  = rst_en_q;
      ctrl_word[BIT_WDEN]   = wd_en_q;
      limit_word                      = '0;
      limit_word[CNT_W-1:0]           = limit_q;
      limit_word[CNT_SHIFT +: CNT_W]  = count;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_ctrl)       bus_rdata = ctrl_word;
         else if (sel_limit) bus_rdata = limit_word;
      end
   end

   // R4: the restart word never returns data
   p_kick_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel_kick) |-> (bus_rdata == '0));
   // R3: a limit write lands in the lower half only
   p_limit_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_limit) |=> (limit == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: rtl/tickdog_prescale.sv
`timescale 1ns/1ps
module tickdog_prescale #(
   parameter int unsigned DIV_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt;
   logic [DIV_W-1:0] last;

   // divide values 0 and 1 both mean one tick per clock
   assign last = (div <= DIV_W'(1)) ? '0 : (div - DIV_W'(1));
   assign tick = run && (pcnt >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (restart) begin
         pcnt <= '0;
      end else if (run) begin
         pcnt <= tick ? '0 : (pcnt + DIV_W'(1));
      end
   end

   // R5: no tick leaves a stopped prescaler
   p_tick_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);
   // R6: a restart always leaves the prescaler at the start of an interval
   p_restart_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
endmodule

// File: rtl/tickdog_counter.sv
`timescale 1ns/1ps
module tickdog_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             kick,
   input  logic             rst_en,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             restart,
   output logic             rst_req
);
   logic expire;
   logic fire;

   assign expire  = run && (count == limit);
   assign restart = kick || expire;
   assign fire    = expire && rst_en && !kick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (restart) begin
         count <= '0;
      end else if (run && tick) begin
         count <= count + CNT_W'(1);
      end
   end

   generate
      if (HOLD_CYC == 1) begin : g_hold_one
         logic req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else        req_q <= fire;
         end
         assign rst_req = req_q;
      end else begin : g_hold_many
         localparam int unsigned HW = $clog2(HOLD_CYC + 1);
         logic [HW-1:0] hcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              hcnt <= '0;
            else if (fire)           hcnt <= HW'(HOLD_CYC);
            else if (hcnt != '0)     hcnt <= hcnt - HW'(1);
         end
         assign rst_req = (hcnt != '0);
      end
   endgenerate

   // R4: a restart write zeroes the count
   p_kick_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (count == '0));
   // R5: a stopped watchdog keeps its count
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !kick) |=> $stable(count));
   // R6: the count only steps by one between restarts
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !kick && (count != limit)) |=>
         ((count == $past(count)) || (count == $past(count) + CNT_W'(1))));
   // R7: expiry wraps the count
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (count == limit)) |=> (count == '0));
   // R8: an enabled expiry raises the request on the next cycle
   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (count == limit) && rst_en && !kick) |=> rst_req);
   // R8 / R10: the request never rises without an enabled, unkicked expiry
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_req && !(run && (count == limit) && rst_en && !kick)) |=> !rst_req);
endmodule

// File: rtl/tickdog_top.sv
`timescale 1ns/1ps
module tickdog_top
   import tickdog_pkg::*;
#(
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned DIV_W    = 18,
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned HOLD_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rst_req
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("tickdog_top: ADDR_W must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > MAX_DIV_W) begin : g_bad_div
         $error("tickdog_top: DIV_W must be 1..18");
      end
      if (CNT_W < 2 || CNT_W > MAX_CNT_W) begin : g_bad_cnt
         $error("tickdog_top: CNT_W must be 2..16");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("tickdog_top: HOLD_CYC must be at least 1");
      end
   endgenerate

   logic             run, rst_en, kick, tick, restart;
   logic [DIV_W-1:0] div;
   logic [CNT_W-1:0] limit, count;

   tickdog_regs #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count(count), .run(run), .rst_en(rst_en),
      .div(div), .limit(limit), .kick(kick)
   );

   tickdog_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
      .div(div), .tick(tick)
   );

   tickdog_counter #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .kick(kick),
      .rst_en(rst_en), .limit(limit), .count(count),
      .restart(restart), .rst_req(rst_req)
   );
endmodule

// File: tb/sim_tickdog_top.sv
`timescale 1ns/1ps
module sim_tickdog_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd2;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b1;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rst_req;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   tickdog_top u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rst_req(rst_req)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0] m_ctrl = '0;
   int unsigned m_lim = 0, m_cnt = 0, m_pc = 0, m_pul = 0;

   function automatic logic [31:0] exp_rdata();
      if (!bus_rd) return '0;
      case (bus_addr)
         2'd0: return m_ctrl;
         2'd2: return {m_cnt[15:0], m_lim[15:0]};
         default: return '0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_lim = 0; m_cnt = 0; m_pc = 0; m_pul = 0;
      end else begin
         bit run, kick, expire, tick;
         int unsigned d, last;
         run    = m_ctrl[18] && m_ctrl[24] && m_ctrl[25];
         d      = m_ctrl[17:0];
         last   = (d <= 1) ? 0 : d - 1;
         kick   = bus_wr && (bus_addr == 2'd3);
         expire = run && (m_cnt == m_lim);
         tick   = run && (m_pc >= last);
         if (expire && m_ctrl[21] && !kick) m_pul = 4;
         else if (m_pul > 0) m_pul = m_pul - 1;
         if (kick || expire) begin
            m_cnt = 0; m_pc = 0;
         end else if (run) begin
            if (tick) begin m_cnt = (m_cnt + 1) % 65536; m_pc = 0; end
            else m_pc = m_pc + 1;
         end
         if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata & 32'h0327_FFFF;
         if (bus_wr && bus_addr == 2'd2) m_lim = bus_wdata[15:0];
      end
      #1;
      if (rst_n && !done) begin
         chk({phase, " model rdata"}, bus_rdata, exp_rdata());
         chk({phase, " model rst_req"}, {31'd0, rst_req}, {31'd0, (m_pul > 0)});
      end
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 2'd2;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_addr = 2'd2;
   endtask

   task automatic count_req(input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         if (rst_req) highs++;
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(5.0 * 150000);
      checks++; failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] v, v1;
      int highs;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      phase = "R1";
      rd(2'd0, v); chk("R1 ctrl after reset", v, 32'h0);
      rd(2'd2, v); chk("R1 limit after reset", v, 32'h0);
      chk("R1 rst_req after reset", {31'd0, rst_req}, 32'h0);

      phase = "R2";
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R2 ctrl readback mask", v, 32'h0327_FFFF);
      wr(2'd0, 32'h0);
      bus_rd = 1'b0; #1; chk("R4 rdata idle zero", bus_rdata, 32'h0);

      phase = "R3";
      wr(2'd2, 32'hABCD_1234);
      rd(2'd2, v); chk("R3 count half not writable", v, 32'h0000_1234);

      phase = "R6";
      wr(2'd2, 32'h0000_FFFF);
      wr(2'd0, 32'h0304_0003);
      wr(2'd3, 32'h0);
      repeat (29) @(posedge clk);
      @(posedge clk); #1;
      chk("R6 count after 30 cycles at divide 3", bus_rdata, 32'h000A_FFFF);

      phase = "R5";
      wr(2'd0, 32'h0204_0003);
      rd(2'd2, v1);
      repeat (20) @(negedge clk);
      rd(2'd2, v); chk("R5 count held with counter clock off", v, v1);

      phase = "R9";
      wr(2'd0, 32'h0300_0003);
      rd(2'd0, v); chk("R9 fields kept when enable cleared", v, 32'h0300_0003);
      rd(2'd2, v); chk("R9 count kept when enable cleared", v, v1);

      phase = "R4";
      wr(2'd3, 32'hDEAD_BEEF);
      rd(2'd2, v); chk("R4 kick zeroes count", v, 32'h0000_FFFF);
      rd(2'd3, v); chk("R4 kick word reads zero", v, 32'h0);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, v); chk("R4 reserved word reads zero", v, 32'h0);
      rd(2'd0, v); chk("R4 reserved write ignored", v, 32'h0300_0003);

      phase = "R8";
      wr(2'd0, 32'h0324_0001);
      wr(2'd2, 32'd20);
      wr(2'd3, 32'h0);
      count_req(30, highs);
      chk("R8 reset pulse length", highs, 32'd4);

      phase = "R7";
      wr(2'd2, 32'd6);
      wr(2'd3, 32'h0);
      repeat (7) @(posedge clk); #1;
      chk("R7 count wrapped after expiry", bus_rdata, 32'h0000_0006);

      phase = "R8";
      wr(2'd0, 32'h0304_0001);
      wr(2'd2, 32'd20);
      wr(2'd3, 32'h0);
      count_req(30, highs);
      chk("R8 no pulse with reset enable clear", highs, 32'd0);

      phase = "R10";
      wr(2'd0, 32'h0324_0001);
      wr(2'd2, 32'd5);
      wr(2'd3, 32'h0);
      repeat (4) @(negedge clk);
      wr(2'd3, 32'h0);
      count_req(5, highs);
      chk("R10 kick beats expiry", highs, 32'd0);

      wr(2'd0, 32'h0);
      repeat (5) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule